// File: doc/BRIEF.md
# Extended-Mode CPU Address Generator

This block turns one memory access request per cycle into a 24-bit bus address with a read or write strobe. It also produces the next program counter and stack pointer for a 16-bit processor that can still run as an 8-bit core. The caller supplies the access kind, an offset, write data and the current register values: program counter, program bank, data bank, direct-page base, stack pointer and the emulation flag. The address and the strobes are combinational from the request. The next PC, the next S and the emulation flag are captured on the rising clock edge whenever a request is valid.

Emulation mode changes two kinds of access. Stack pushes and pulls move only the low byte of S, so the stack stays in its 256-byte page. Direct-page accesses with a page-aligned base stay inside that page. A separate set of "full" kinds always uses 16-bit arithmetic, whatever the mode.

Top module: `cpu_addr_gen`

## Requirements
- R1: Kind 0 (fetch) reads at {pbr_i, pc_i}. One edge later pc_q equals pc_i+1, wrapping within 16 bits, and the bank byte is never affected.
- R2: Kind 1 (push) writes req_wdata at {0x00, s_i}. s_q then becomes s_i-1. With emu_i=1 only the low byte decrements, wrapping within the page, and the high byte is kept.
- R3: Kind 2 (pull) reads at {0x00, s_i+1}, and s_q becomes that incremented value. With emu_i=1 only the low byte increments, wrapping within the page.
- R4: Kinds 3 (full push) and 4 (full pull) behave like push and pull but always use 16-bit S arithmetic, ignoring emu_i.
- R5: Kind 5 (direct page) with emu_i=1 and d_i[7:0]=0 accesses {0x00, d_i[15:8], req_off[7:0]}.
- R6: Kind 5 in all other cases, and kind 6 (full direct page) always, accesses {0x00, (d_i+req_off) mod 2^16}.
- R7: Kind 7 (data bank) accesses ({dbr_i, 0x0000} + req_off) mod 2^24, so a carry reaches the bank byte.
- R8: Kind 8 (stack relative) accesses {0x00, (s_i+req_off) mod 2^16}.
- R9: For kinds 5 to 8, req_we=1 gives a write and req_we=0 gives a read. bus_rd and bus_wr are never both high, and bus_wdata equals req_wdata during a write and is 0 otherwise.
- R10: With req_valid=0 both strobes and bus_addr are 0, and pc_q, s_q and emu_q hold. With a valid request, pc_q takes pc_i for non-fetch kinds, s_q takes s_i for non-stack kinds, and emu_q takes emu_i.
- R11: While rst is high, pc_q=0x0000, s_q=0x01FF, emu_q=1, and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_kind | input | 4 | Access kind code, 0 to 8 |
| req_we | input | 1 | Write select for kinds 5 to 8 |
| req_off | input | 24 | Offset added to the base |
| req_wdata | input | 8 | Data for a write access |
| pc_i | input | 16 | Current program counter |
| pbr_i | input | 8 | Program bank |
| dbr_i | input | 8 | Data bank |
| d_i | input | 16 | Direct-page base |
| s_i | input | 16 | Current stack pointer |
| emu_i | input | 1 | Emulation flag for this request |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| pc_q | output | 16 | Registered next program counter |
| s_q | output | 16 | Registered next stack pointer |
| emu_q | output | 1 | Registered emulation flag |

## Verification
bus_addr, bus_rd, bus_wr and bus_wdata follow the request in the same cycle. The bench drives each request at a falling edge and samples these outputs 1 ns later, before the next rising edge. pc_q, s_q and emu_q pass through one register, so they are sampled 1 ns after the rising edge that captures the request. The hold and reset checks use the same points, in the cycle after a request is withdrawn or reset is applied.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

    localparam int WORD_W = 16;
    localparam int BANK_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = BANK_W + WORD_W;
    localparam int OFF_W  = ADDR_W;
    localparam int KIND_W = 4;
    localparam int PAGE_W = WORD_W / 2;

    localparam logic [WORD_W-1:0] STACK_RESET = 16'h01FF;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef enum logic [KIND_W-1:0] {
        KIND_FETCH     = 4'd0,
        KIND_PUSH      = 4'd1,
        KIND_PULL      = 4'd2,
        KIND_PUSH_FULL = 4'd3,
        KIND_PULL_FULL = 4'd4,
        KIND_DIR       = 4'd5,
        KIND_DIR_FULL  = 4'd6,
        KIND_BANK      = 4'd7,
        KIND_STK_REL   = 4'd8
    } kind_e;

    typedef struct packed {
        logic  hit;
        logic  is_rd;
        logic  is_wr;
        addr_t addr;
    } acc_t;

    // Step the stack pointer by one; in page mode only the low byte moves.
    function automatic word_t stack_step(word_t s, logic up, logic page_only);
        logic [PAGE_W-1:0] lo;
        word_t             full;
        lo   = up ? s[PAGE_W-1:0] + 1'b1 : s[PAGE_W-1:0] - 1'b1;
        full = up ? s + 1'b1 : s - 1'b1;
        return page_only ? {s[WORD_W-1:PAGE_W], lo} : full;
    endfunction

    function automatic addr_t bank0(word_t a);
        return {{BANK_W{1'b0}}, a};
    endfunction

endpackage

// File: rtl/addr_stack_unit.sv
module addr_stack_unit
    import addr_gen_pkg::*;
(
    input  kind_e kind,
    input  logic  emu,
    input  word_t pc,
    input  word_t s,
    input  bank_t pbr,
    output acc_t  acc,
    output word_t pc_nxt,
    output word_t s_nxt
);

    word_t s_up;
    word_t s_dn;
    logic  page_only;

    always_comb begin
        page_only = emu && (kind == KIND_PUSH || kind == KIND_PULL);
        s_up      = stack_step(s, 1'b1, page_only);
        s_dn      = stack_step(s, 1'b0, page_only);
    end

    always_comb begin
        acc    = '0;
        pc_nxt = pc;
        s_nxt  = s;
        unique case (kind)
            KIND_FETCH: begin
                acc    = '{hit: 1'b1, is_rd: 1'b1, is_wr: 1'b0, addr: {pbr, pc}};
                pc_nxt = pc + 1'b1;
            end
            KIND_PUSH, KIND_PUSH_FULL: begin
                acc   = '{hit: 1'b1, is_rd: 1'b0, is_wr: 1'b1, addr: bank0(s)};
                s_nxt = s_dn;
            end
            KIND_PULL, KIND_PULL_FULL: begin
                acc   = '{hit: 1'b1, is_rd: 1'b1, is_wr: 1'b0, addr: bank0(s_up)};
                s_nxt = s_up;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/addr_data_unit.sv
module addr_data_unit
    import addr_gen_pkg::*;
(
    input  kind_e kind,
    input  logic  we,
    input  logic  emu,
    input  word_t d,
    input  word_t s,
    input  bank_t dbr,
    input  off_t  off,
    output acc_t  acc
);

    word_t off16;
    word_t dir_sum;
    word_t stk_sum;
    addr_t bank_sum;
    logic  page_wrap;
    addr_t dir_addr;

    always_comb begin
        off16     = off[WORD_W-1:0];
        dir_sum   = d + off16;
        stk_sum   = s + off16;
        bank_sum  = {dbr, {WORD_W{1'b0}}} + off;
        page_wrap = (kind == KIND_DIR) && emu && (d[PAGE_W-1:0] == '0);
        dir_addr  = page_wrap ? bank0({d[WORD_W-1:PAGE_W], off[PAGE_W-1:0]})
                              : bank0(dir_sum);
    end

    always_comb begin
        acc = '0;
        unique case (kind)
            KIND_DIR, KIND_DIR_FULL: acc = '{hit: 1'b1, is_rd: !we, is_wr: we, addr: dir_addr};
            KIND_BANK:               acc = '{hit: 1'b1, is_rd: !we, is_wr: we, addr: bank_sum};
            KIND_STK_REL:            acc = '{hit: 1'b1, is_rd: !we, is_wr: we, addr: bank0(stk_sum)};
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu_addr_gen.sv
module cpu_addr_gen
    import addr_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              req_we,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [BANK_W-1:0] pbr_i,
    input  logic [BANK_W-1:0] dbr_i,
    input  logic [WORD_W-1:0] d_i,
    input  logic [WORD_W-1:0] s_i,
    input  logic              emu_i,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] pc_q,
    output logic [WORD_W-1:0] s_q,
    output logic              emu_q
);

    kind_e kind;
    acc_t  stk_acc;
    acc_t  dat_acc;
    acc_t  sel;
    word_t pc_nxt;
    word_t s_nxt;
    logic  live;

    assign kind = kind_e'(req_kind);

    addr_stack_unit stk_u (
        .kind   (kind),
        .emu    (emu_i),
        .pc     (pc_i),
        .s      (s_i),
        .pbr    (pbr_i),
        .acc    (stk_acc),
        .pc_nxt (pc_nxt),
        .s_nxt  (s_nxt)
    );

    addr_data_unit dat_u (
        .kind (kind),
        .we   (req_we),
        .emu  (emu_i),
        .d    (d_i),
        .s    (s_i),
        .dbr  (dbr_i),
        .off  (req_off),
        .acc  (dat_acc)
    );

    always_comb begin
        sel       = stk_acc.hit ? stk_acc : dat_acc;
        live      = req_valid && !rst && sel.hit;
        bus_addr  = live ? sel.addr : '0;
        bus_rd    = live && sel.is_rd;
        bus_wr    = live && sel.is_wr;
        bus_wdata = bus_wr ? req_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            s_q   <= STACK_RESET;
            emu_q <= 1'b1;
        end else if (req_valid) begin
            pc_q  <= pc_nxt;
            s_q   <= s_nxt;
            emu_q <= emu_i;
        end
    end

endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk
    import addr_gen_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [KIND_W-1:0] req_kind,
    input logic [WORD_W-1:0] pc_i,
    input logic [BANK_W-1:0] pbr_i,
    input logic [WORD_W-1:0] s_i,
    input logic              emu_i,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [WORD_W-1:0] pc_q,
    input logic [WORD_W-1:0] s_q,
    input logic              emu_q
);

    logic fetch_req;
    logic page_stack_req;
    logic full_pull_req;
    logic bank0_req;

    always_comb begin
        fetch_req      = req_valid && req_kind == KIND_FETCH;
        page_stack_req = req_valid && emu_i && (req_kind == KIND_PUSH || req_kind == KIND_PULL);
        full_pull_req  = req_valid && req_kind == KIND_PULL_FULL;
        bank0_req      = req_valid && (req_kind inside {KIND_PUSH, KIND_PULL, KIND_PUSH_FULL,
                                                         KIND_PULL_FULL, KIND_DIR, KIND_DIR_FULL,
                                                         KIND_STK_REL});
    end

    AST_FETCH_BANK: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> bus_rd && bus_addr[ADDR_W-1:WORD_W] == pbr_i); // R1
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> pc_q == $past(pc_i) + 16'd1); // R1
    AST_STACK_PAGE: assert property (@(posedge clk) disable iff (rst)
        page_stack_req |=> s_q[WORD_W-1:PAGE_W] == $past(s_i[WORD_W-1:PAGE_W])); // R2
    AST_FULL_PULL: assert property (@(posedge clk) disable iff (rst)
        full_pull_req |=> s_q == $past(s_i) + 16'd1); // R4
    AST_BANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        bank0_req |-> bus_addr[ADDR_W-1:WORD_W] == '0); // R8
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(pc_q) && $stable(s_q) && $stable(emu_q)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !bus_rd && !bus_wr && bus_addr == '0); // R10

endmodule

bind cpu_addr_gen addr_gen_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .pc_i      (pc_i),
    .pbr_i     (pbr_i),
    .s_i       (s_i),
    .emu_i     (emu_i),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .pc_q      (pc_q),
    .s_q       (s_q),
    .emu_q     (emu_q)
);

// File: tb/cpu_addr_gen_tb_top.sv
`timescale 1ns/100ps
module cpu_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [3:0]  req_kind;
    logic        req_we;
    logic [23:0] req_off;
    logic [7:0]  req_wdata;
    logic [15:0] pc_i;
    logic [7:0]  pbr_i;
    logic [7:0]  dbr_i;
    logic [15:0] d_i;
    logic [15:0] s_i;
    logic        emu_i;
    logic [23:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [15:0] pc_q;
    logic [15:0] s_q;
    logic        emu_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cpu_addr_gen dut_i (.*);

    typedef struct packed {
        logic [3:0]  kind;
        logic        we;
        logic        emu;
        logic [15:0] pc;
        logic [15:0] s;
        logic [15:0] d;
        logic [23:0] off;
        logic [7:0]  pbr;
        logic [7:0]  dbr;
        logic [7:0]  wd;
        logic [23:0] ea;
        logic        er;
        logic        ew;
        logic [15:0] epc;
        logic [15:0] es;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // kind we emu pc      s       d       off        pbr    dbr    wd     ea          er    ew    epc     es      rq
        '{4'd0,1'b0,1'b1,16'h1234,16'h01FF,16'h0000,24'h000000,8'h7E,8'h00,8'h00,24'h7E1234,1'b1,1'b0,16'h1235,16'h01FF,8'd1}, // R1
        '{4'd0,1'b0,1'b0,16'hFFFF,16'h1FF0,16'h0000,24'h000000,8'h03,8'h00,8'h00,24'h03FFFF,1'b1,1'b0,16'h0000,16'h1FF0,8'd1}, // R1 wrap
        '{4'd1,1'b0,1'b1,16'h4000,16'h0100,16'h0000,24'h000000,8'h00,8'h00,8'hA5,24'h000100,1'b0,1'b1,16'h4000,16'h01FF,8'd2}, // R2 page
        '{4'd1,1'b0,1'b0,16'h4000,16'h0100,16'h0000,24'h000000,8'h00,8'h00,8'h5A,24'h000100,1'b0,1'b1,16'h4000,16'h00FF,8'd2}, // R2 native
        '{4'd2,1'b0,1'b1,16'h4000,16'h01FF,16'h0000,24'h000000,8'h00,8'h00,8'hEE,24'h000100,1'b1,1'b0,16'h4000,16'h0100,8'd3}, // R3 page
        '{4'd2,1'b0,1'b0,16'h4000,16'h01FF,16'h0000,24'h000000,8'h00,8'h00,8'h00,24'h000200,1'b1,1'b0,16'h4000,16'h0200,8'd3}, // R3 native
        '{4'd3,1'b0,1'b1,16'h4000,16'h0100,16'h0000,24'h000000,8'h00,8'h00,8'hC3,24'h000100,1'b0,1'b1,16'h4000,16'h00FF,8'd4}, // R4 push
        '{4'd4,1'b0,1'b1,16'h4000,16'h01FF,16'h0000,24'h000000,8'h00,8'h00,8'h00,24'h000200,1'b1,1'b0,16'h4000,16'h0200,8'd4}, // R4 pull
        '{4'd5,1'b0,1'b1,16'h4000,16'h01FF,16'h2100,24'h000105,8'h00,8'h00,8'h00,24'h002105,1'b1,1'b0,16'h4000,16'h01FF,8'd5}, // R5
        '{4'd5,1'b0,1'b1,16'h4000,16'h01FF,16'h2101,24'h0000FF,8'h00,8'h00,8'h00,24'h002200,1'b1,1'b0,16'h4000,16'h01FF,8'd6}, // R6 unaligned
        '{4'd5,1'b0,1'b0,16'h4000,16'h01FF,16'h2100,24'h000105,8'h00,8'h00,8'h00,24'h002205,1'b1,1'b0,16'h4000,16'h01FF,8'd6}, // R6 native
        '{4'd6,1'b0,1'b1,16'h4000,16'h01FF,16'h2100,24'h000105,8'h00,8'h00,8'h00,24'h002205,1'b1,1'b0,16'h4000,16'h01FF,8'd6}, // R6 full
        '{4'd5,1'b1,1'b0,16'h4000,16'h01FF,16'hFFF0,24'h000020,8'h00,8'h00,8'h3C,24'h000010,1'b0,1'b1,16'h4000,16'h01FF,8'd9}, // R9 R6 wrap
        '{4'd7,1'b0,1'b1,16'h4000,16'h01FF,16'h0000,24'h010005,8'h00,8'h12,8'h00,24'h130005,1'b1,1'b0,16'h4000,16'h01FF,8'd7}, // R7 carry
        '{4'd7,1'b1,1'b0,16'h4000,16'h01FF,16'h0000,24'h010000,8'h00,8'hFF,8'h99,24'h000000,1'b0,1'b1,16'h4000,16'h01FF,8'd7}, // R7 wrap
        '{4'd8,1'b0,1'b1,16'h4000,16'h01F0,16'h0000,24'h000005,8'h00,8'h00,8'h00,24'h0001F5,1'b1,1'b0,16'h4000,16'h01F0,8'd8}, // R8
        '{4'd8,1'b1,1'b0,16'h4000,16'hFFF0,16'h0000,24'h000020,8'h00,8'h00,8'h77,24'h000010,1'b0,1'b1,16'h4000,16'hFFF0,8'd8}  // R8 wrap
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        req_valid = 1'b1;
        req_kind  = v.kind;
        req_we    = v.we;
        emu_i     = v.emu;
        pc_i      = v.pc;
        s_i       = v.s;
        d_i       = v.d;
        req_off   = v.off;
        pbr_i     = v.pbr;
        dbr_i     = v.dbr;
        req_wdata = v.wd;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        apply(VECS[0]);
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state and no strobes while reset is held
        check("R11", "bus_rd in reset", 32'(bus_rd), 32'd0);
        check("R11", "pc_q in reset", 32'(pc_q), 32'h0000);
        check("R11", "s_q in reset", 32'(s_q), 32'h01FF);
        check("R11", "emu_q in reset", 32'(emu_q), 32'd1);
        @(negedge clk);
        rst       = 1'b0;
        req_valid = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string tag;
            @(negedge clk);
            apply(VECS[i]);
            tag = $sformatf("R%0d", VECS[i].rq);
            #1;
            check(tag, "bus_addr", 32'(bus_addr), 32'(VECS[i].ea));
            check(tag, "bus_rd", 32'(bus_rd), 32'(VECS[i].er));
            check(tag, "bus_wr", 32'(bus_wr), 32'(VECS[i].ew));
            check(tag, "bus_wdata", 32'(bus_wdata), VECS[i].ew ? 32'(VECS[i].wd) : 32'd0);
            @(posedge clk);
            #1;
            check(tag, "pc_q", 32'(pc_q), 32'(VECS[i].epc));
            check(tag, "s_q", 32'(s_q), 32'(VECS[i].es));
            check(tag, "emu_q", 32'(emu_q), 32'(VECS[i].emu));
        end

        // R10: withdrawn request leaves the bus quiet and the registers held
        @(negedge clk);
        req_valid = 1'b0;
        req_kind  = 4'd0;
        pc_i      = 16'h0AAA;
        s_i       = 16'h0BBB;
        emu_i     = 1'b1;
        #1;
        check("R10", "idle bus_rd", 32'(bus_rd), 32'd0);
        check("R10", "idle bus_addr", 32'(bus_addr), 32'd0);
        @(posedge clk);
        #1;
        check("R10", "idle pc_q", 32'(pc_q), 32'h4000);
        check("R10", "idle s_q", 32'(s_q), 32'hFFF0);
        check("R10", "idle emu_q", 32'(emu_q), 32'd0);

        // R10: a valid fetch passes S through and captures the flag
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        check("R10", "fetch pc_q", 32'(pc_q), 32'h0AAB);
        check("R10", "pass s_q", 32'(s_q), 32'h0BBB);
        check("R10", "emu_q load", 32'(emu_q), 32'd1);

        // R11: reset with a live request blocks strobes and restores state
        @(negedge clk);
        rst      = 1'b1;
        req_kind = 4'd1;
        #1;
        check("R11", "bus_wr in reset", 32'(bus_wr), 32'd0);
        @(posedge clk);
        #1;
        check("R11", "s_q after reset", 32'(s_q), 32'h01FF);
        check("R11", "pc_q after reset", 32'(pc_q), 32'h0000);

        done = 1'b1;
        finish_run();
    end

endmodule